// File: doc/BRIEF.md
# Wake-Up Event Status Latch

This block records which wake sources have fired while a system sits in soft-off, and it produces the active-low power-on request from those records. It watches five inputs: two serial receive-data lines, an active-low ring-indicator line, a consumer-IR wake line and an active-low push-button line. Each input is synchronized and edge-detected. Every detected edge sets a sticky bit in one 8-bit status register. Software reads that register at configuration index 0xB3 over a simple register bus, and the read clears it.

Four of the sources can wake the system: the two receive lines, ring and IR. Each has its own enable. When an enabled source has its bit set, the power-on output is held low. The button is recorded in the status register for software, but it never reaches the power-on output. Writes to the register are accepted on the bus and change nothing.

Top module: `wake_status_latch`

## Requirements
- R1: After reset the status register reads 0x00 and `pwr_on_n` is high.
- R2: A high-to-low edge on `rxd_a` sets status bit 0. A low-to-high edge on `rxd_a` sets nothing. The bit is visible three rising clock edges after the pin changes.
- R3: A high-to-low edge on `rxd_b` sets status bit 1.
- R4: A high-to-low edge on `ring_n`, which is ring asserted, sets status bit 3.
- R5: A low-to-high edge on `ir_wake` sets status bit 5.
- R6: A high-to-low edge on `button_n` sets status bit 2. Bit 2 never pulls `pwr_on_n` low.
- R7: Set bits stay set until a read with `reg_rd` high and `reg_addr` equal to 0xB3. That read returns the register on `reg_rdata` in the same cycle and clears it at the clock edge. A read at any other address returns 0x00 and clears nothing.
- R8: Bits 4, 6 and 7 always read 0.
- R9: `pwr_on_n` is low exactly when an enabled wake bit is set. The enables map as follows: `wake_en[0]` to bit 0, `wake_en[1]` to bit 1, `wake_en[2]` to bit 3, `wake_en[3]` to bit 5.
- R10: An edge whose bit would be set on the same clock edge as a clearing read leaves that bit set.
- R11: A write (`reg_wr` at 0xB3) leaves every status bit unchanged.
- R12: An input held at its active level gives one event only. After that event is read and cleared, the bit stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset from the standby-supply power-on reset |
| rxd_a | input | 1 | First serial receive-data pin, asynchronous |
| rxd_b | input | 1 | Second serial receive-data pin, asynchronous |
| ring_n | input | 1 | Ring indicator, active low, asynchronous |
| ir_wake | input | 1 | Consumer-IR wake indication, active high, asynchronous |
| button_n | input | 1 | Push button, active low, asynchronous |
| reg_addr | input | 8 | Register bus index |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data, ignored by the status register |
| reg_rdata | output | 8 | Read data, combinational while `reg_rd` is high |
| wake_en | input | 4 | Per-source wake enables for bits 0, 1, 3, 5 |
| pwr_on_n | output | 1 | Active-low power-on request |

## Verification
The bench builds the block with its default parameters: a two-stage synchronizer, an 8-bit register, an 8-bit index and a status index of 0xB3. With two stages, every input reaches the status register after exactly three edges. That fixed latency lets the bench place a clearing read on the exact edge where a ring event lands. A table then combines single sources, all sources together and mixed enables, so that the button's exclusion from the power-on path and each enable mapping are exercised.

// File: rtl/wake_pkg.sv
package wake_pkg;
   localparam int unsigned NUM_SRC = 5;
   // source order: 0 rxd_a, 1 rxd_b, 2 button, 3 ring, 4 ir
   localparam int unsigned SRC_BIT [NUM_SRC] = '{0, 1, 2, 3, 5};
   localparam logic [NUM_SRC-1:0] SRC_ACT_LOW = 5'b01111;
   localparam int unsigned NUM_WAKE = 4;
   // wake enables map onto these status bits
   localparam int unsigned WAKE_BIT [NUM_WAKE] = '{0, 1, 3, 5};
   localparam int unsigned MIN_DATA_W = 6;
endpackage

// File: rtl/wake_edge.sv
module wake_edge #(
   parameter int unsigned STAGES    = 2,
   parameter bit          ACTIVE_LOW = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic ev
);
   localparam logic IDLE = ACTIVE_LOW;

   if (STAGES < 2) begin : g_bad_stages
      $error("wake_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              prev_q;
   logic              cur;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= {STAGES{IDLE}};
         prev_q <= IDLE;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], pin};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign cur = sync_q[STAGES-1];

   if (ACTIVE_LOW) begin : g_fall
      assign ev = prev_q & ~cur;
   end else begin : g_rise
      assign ev = cur & ~prev_q;
   end

   // R12
   edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev |=> !ev);
endmodule

// File: rtl/wake_status_reg.sv
module wake_status_reg #(
   parameter int unsigned DATA_W     = 8,
   parameter logic [DATA_W-1:0] VALID_MASK = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] set_vec,
   input  logic              rd_clr,
   input  logic              wr_hit,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] status
);
   logic [DATA_W-1:0] keep;
   logic [DATA_W-1:0] status_d;

   assign keep     = rd_clr ? '0 : status;
   assign status_d = (keep | set_vec) & VALID_MASK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status <= '0;
      else        status <= status_d;
   end

   // R7
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_clr |=> ((status & $past(status)) == $past(status)));

   // R7
   read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && set_vec == '0) |=> status == '0);

   // R10
   event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec != '0) |=> ((status & $past(set_vec & VALID_MASK))
                           == $past(set_vec & VALID_MASK)));

   // R11
   write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && !rd_clr && set_vec == '0 && wr_data != '0) |=> $stable(status));
endmodule

// File: rtl/wake_status_latch.sv
module wake_status_latch
   import wake_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned ADDR_W      = 8,
   parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'hB3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rxd_a,
   input  logic              rxd_b,
   input  logic              ring_n,
   input  logic              ir_wake,
   input  logic              button_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_rd,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [NUM_WAKE-1:0] wake_en,
   output logic              pwr_on_n
);
   if (DATA_W < MIN_DATA_W) begin : g_bad_width
      $error("wake_status_latch: DATA_W too small for bit 5");
   end

   function automatic logic [DATA_W-1:0] src_mask();
      logic [DATA_W-1:0] m = '0;
      for (int i = 0; i < NUM_SRC; i++) m[SRC_BIT[i]] = 1'b1;
      return m;
   endfunction

   localparam logic [DATA_W-1:0] VALID_MASK = src_mask();

   logic [NUM_SRC-1:0] pins;
   logic [NUM_SRC-1:0] ev;
   logic [DATA_W-1:0]  set_vec;
   logic [DATA_W-1:0]  en_map;
   logic [DATA_W-1:0]  status;
   logic               addr_hit;
   logic               rd_clr;
   logic               wr_hit;

   assign pins = {ir_wake, ring_n, button_n, rxd_b, rxd_a};

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      wake_edge #(
         .STAGES    (SYNC_STAGES),
         .ACTIVE_LOW(SRC_ACT_LOW[s])
      ) u_edge (
         .clk  (clk),
         .rst_n(rst_n),
         .pin  (pins[s]),
         .ev   (ev[s])
      );
   end

   always_comb begin
      set_vec = '0;
      for (int i = 0; i < NUM_SRC; i++) set_vec[SRC_BIT[i]] = ev[i];
   end

   always_comb begin
      en_map = '0;
      for (int i = 0; i < NUM_WAKE; i++) en_map[WAKE_BIT[i]] = wake_en[i];
   end

   assign addr_hit = (reg_addr == STATUS_ADDR);
   assign rd_clr   = reg_rd & addr_hit;
   assign wr_hit   = reg_wr & addr_hit;

   wake_status_reg #(
      .DATA_W    (DATA_W),
      .VALID_MASK(VALID_MASK)
   ) u_status (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_vec(set_vec),
      .rd_clr (rd_clr),
      .wr_hit (wr_hit),
      .wr_data(reg_wdata),
      .status (status)
   );

   assign reg_rdata = rd_clr ? status : '0;
   assign pwr_on_n  = ~|(status & en_map);

   // R6
   button_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status[SRC_BIT[2]] && (status & ~(DATA_W'(1) << SRC_BIT[2])) == '0) |-> pwr_on_n);

   // R8
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata & ~VALID_MASK) == '0);

   // R7
   miss_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && !addr_hit) |-> reg_rdata == '0);
endmodule

// File: tb/wake_status_latch_bench.sv
module wake_status_latch_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rxd_a = 1'b1, rxd_b = 1'b1, ring_n = 1'b1, ir_wake = 1'b0, button_n = 1'b1;
   logic [7:0] reg_addr = 8'h00;
   logic       reg_rd = 1'b0, reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic [3:0] wake_en = 4'h0;
   logic       pwr_on_n;

   int n_chk = 0;
   int n_fail = 0;
   logic [7:0] got;

   always #10 clk = ~clk;   // 50 MHz

   wake_status_latch u_wake_status_latch (
      .clk(clk), .rst_n(rst_n), .rxd_a(rxd_a), .rxd_b(rxd_b), .ring_n(ring_n),
      .ir_wake(ir_wake), .button_n(button_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .wake_en(wake_en), .pwr_on_n(pwr_on_n));

   // fire bits: 0 rxd_a, 1 rxd_b, 2 button, 3 ring, 4 ir
   typedef struct packed {
      logic [4:0] fire;
      logic [3:0] en;
      logic [7:0] exp_stat;
      logic       exp_pwr;
      logic [7:0] req;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{5'b00001, 4'b0001, 8'h01, 1'b0, 8'd2},
      '{5'b00010, 4'b0000, 8'h02, 1'b1, 8'd3},
      '{5'b01000, 4'b0100, 8'h08, 1'b0, 8'd4},
      '{5'b10000, 4'b1000, 8'h20, 1'b0, 8'd5},
      '{5'b00100, 4'b1111, 8'h04, 1'b1, 8'd6},
      '{5'b11111, 4'b1111, 8'h2F, 1'b0, 8'd9},
      '{5'b10001, 4'b0010, 8'h21, 1'b1, 8'd9},
      '{5'b00110, 4'b0010, 8'h06, 1'b0, 8'd6}
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [4:0] m, input logic active);
      if (m[0]) rxd_a    = ~active;
      if (m[1]) rxd_b    = ~active;
      if (m[2]) button_n = ~active;
      if (m[3]) ring_n   = ~active;
      if (m[4]) ir_wake  =  active;
   endtask

   task automatic fire(input logic [4:0] m);
      @(negedge clk); drive(m, 1'b1);
      repeat (4) @(negedge clk);
      drive(m, 1'b0);
      repeat (4) @(negedge clk);
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk); reg_addr = a; reg_rd = 1'b1;
      #2 d = reg_rdata;
      @(negedge clk); reg_rd = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      check("R1 pwr", {7'd0, pwr_on_n}, 8'h01);
      rd(8'hB3, got); check("R1 status", got, 8'h00);

      // R2 R3 R4 R5 R6 R8 R9: table walk
      foreach (VECS[i]) begin
         wake_en = VECS[i].en;
         fire(VECS[i].fire);
         check($sformatf("R%0d/R9 pwr vec%0d", VECS[i].req, i), {7'd0, pwr_on_n}, {7'd0, VECS[i].exp_pwr});
         rd(8'hB3, got);
         check($sformatf("R%0d/R8 stat vec%0d", VECS[i].req, i), got, VECS[i].exp_stat);
         rd(8'hB3, got);
         check($sformatf("R7 cleared vec%0d", i), got, 8'h00);
      end

      // R7: miss read returns zero and keeps status
      wake_en = 4'h0;
      fire(5'b00001);
      rd(8'hB2, got); check("R7 miss read", got, 8'h00);
      rd(8'hB3, got); check("R7 kept after miss", got, 8'h01);

      // R11: writes have no effect
      fire(5'b00010);
      @(negedge clk); reg_addr = 8'hB3; reg_wdata = 8'h00; reg_wr = 1'b1;
      @(negedge clk); reg_wdata = 8'hFF;
      @(negedge clk); reg_wr = 1'b0;
      rd(8'hB3, got); check("R11 write ignored", got, 8'h02);

      // R10: ring event lands on the clearing read's edge
      wake_en = 4'b0100;
      fire(5'b00001);
      @(negedge clk); ring_n = 1'b0;
      @(negedge clk);
      @(negedge clk); reg_addr = 8'hB3; reg_rd = 1'b1;
      #2 got = reg_rdata;
      @(negedge clk); reg_rd = 1'b0;
      check("R10 read before event", got, 8'h01);
      check("R10 pwr after race", {7'd0, pwr_on_n}, 8'h00);
      // R12: ring held low gives no second event
      repeat (4) @(negedge clk);
      rd(8'hB3, got); check("R10 event kept", got, 8'h08);
      repeat (4) @(negedge clk);
      rd(8'hB3, got); check("R12 held level single", got, 8'h00);
      ring_n = 1'b1;
      repeat (4) @(negedge clk);
      rd(8'hB3, got); check("R12 release no event", got, 8'h00);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule